// File: doc/BRIEF.md
# Dual Event Counter with Cascade and Snapshot

This block counts edges on two external event inputs. Each input is first brought into the clock domain through a two-stage synchroniser. The synchronised level is then compared with its previous sample to find edges. Each input has its own polarity select, so either rising or falling edges are counted. Each input drives a 16-bit counter.

A chaining mode joins the two counters into a single 32-bit counter. In this mode, events from input A drive the whole value, and counter B holds the upper half. A host reaches the block over a byte-wide register bus with address, write strobe, write data and combinational read data. Through this bus the host sets the mode bits and requests a snapshot. The snapshot copies all four count bytes into holding registers. The host can then read a value that does not tear, while the live counters keep counting every event.

Top module: `dual_event_counter`

## Requirements
- R1: Address 0 is the control register: bit 0 selects the polarity of input A, bit 1 the polarity of input B, bit 2 enables chaining, and bit 3 is the snapshot command. A write to address 0 stores bits 2:0, and a read returns them in the same positions with bits 7:4 reading 0.
- R2: Counter A counts falling edges of input A when bit 0 is 0 and rising edges when bit 0 is 1; edges of the other direction leave it unchanged.
- R3: With bit 2 at 0, counter B counts falling edges of input B when bit 1 is 0 and rising edges when bit 1 is 1. The two counters are then independent, so events on one input never change the other counter.
- R4: With bit 2 at 1, counter B advances by one exactly when counter A wraps from 0xFFFF to 0 on an input-A event. Input B and bit 1 have no effect on it.
- R5: Each counter wraps from 0xFFFF to 0x0000.
- R6: If an input change is first sampled at clock edge n, the resulting count is updated at edge n+2.
- R7: A write of 1 to bit 3 at edge n makes edge n+1 copy both live counters, with the values they held just before that edge, into the holding registers. An event counted at edge n+1 still reaches the live counter.
- R8: Bit 3 reads 1 during the cycle after the write that set it, and it clears itself at the next edge.
- R9: The holding registers are read at address 1 (counter A bits 7:0), address 2 (counter A bits 15:8), address 3 (counter B bits 7:0) and address 4 (counter B bits 15:8). They change only on a snapshot, never on counting.
- R10: Writes to any address other than 0 change nothing, and reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtInA | input | 1 | Event input A, asynchronous |
| evtInB | input | 1 | Event input B, asynchronous |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |

## Verification
Two functions can land on the same clock edge: the snapshot capture and a counted edge, including a chaining carry. The bench provokes this by raising input A one cycle before the snapshot command. This places the capture on the very edge where the synchronised change is counted. The check is that the holding register shows the count from before the event and that the following snapshot shows the event. A behavioural model compares every read on every cycle, so any overlap of these functions that occurs during the long chaining run is judged as well.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef struct packed {
    logic incA;
    logic incB;
    logic chain;
    logic snap;
  } cntStrobe_t;

  localparam int CTRL_ADDR = 0;
  localparam int BIT_POLA  = 0;
  localparam int BIT_POLB  = 1;
  localparam int BIT_CHAIN = 2;
  localparam int BIT_SNAP  = 3;
endpackage

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_IN      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] evtIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  output cntStrobe_t        strobe,
  output logic [DATA_W-1:0] ctrlRd
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [NUM_IN-1:0] polSel;
  logic [NUM_IN-1:0] edgeHit;
  logic              chainMode;
  logic              snapReq;
  logic              ctrlHit;

  assign ctrlHit = busWr && (busAddr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polSel    <= '0;
      chainMode <= 1'b0;
      snapReq   <= 1'b0;
    end else begin
      snapReq <= 1'b0;
      if (ctrlHit) begin
        polSel    <= {busWrData[BIT_POLB], busWrData[BIT_POLA]};
        chainMode <= busWrData[BIT_CHAIN];
        snapReq   <= busWrData[BIT_SNAP];
      end
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    logic [PIPE_W-1:0] pipe;
    logic              cur;
    logic              prv;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[PIPE_W-2:0], evtIn[i]};
    end
    assign cur = pipe[SYNC_STAGES-1];
    assign prv = pipe[SYNC_STAGES];
    assign edgeHit[i] = polSel[i] ? (cur & ~prv) : (~cur & prv);
  end

  assign strobe.incA  = edgeHit[0];
  assign strobe.incB  = edgeHit[1];
  assign strobe.chain = chainMode;
  assign strobe.snap  = snapReq;
  assign ctrlRd = {{(DATA_W-4){1'b0}}, snapReq, chainMode, polSel};

  // R1: a control write lands in the mode bits one edge later
  p_ctrl_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrlHit |=> (chainMode == $past(busWrData[BIT_CHAIN])) &&
                (polSel == $past({busWrData[BIT_POLB], busWrData[BIT_POLA]})));

  // R8: the snapshot command never survives a cycle without a fresh write
  p_snap_self_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (snapReq && !(ctrlHit && busWrData[BIT_SNAP])) |=> !snapReq);

  // R10: writes elsewhere leave the mode bits alone
  p_ignore_wr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !ctrlHit) |=> $stable(polSel) && $stable(chainMode) && !snapReq);
endmodule

// File: rtl/evc_datapath.sv
module evc_datapath
  import evc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] ctrlRd,
  output logic [DATA_W-1:0] busRdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int LANES = (2 * CNT_W) / DATA_W;

  logic [CNT_W-1:0]   countA, countB, holdA, holdB;
  logic [2*CNT_W-1:0] holdAll;
  logic [DATA_W-1:0]  byteLane [LANES];
  logic               carryA, stepB;

  assign carryA = strobe.incA && (countA == CNT_MAX);
  assign stepB  = strobe.chain ? carryA : strobe.incB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countA <= '0;
      countB <= '0;
      holdA  <= '0;
      holdB  <= '0;
    end else begin
      if (strobe.incA) countA <= countA + 1'b1;
      if (stepB)       countB <= countB + 1'b1;
      if (strobe.snap) begin
        holdA <= countA;
        holdB <= countB;
      end
    end
  end

  assign holdAll = {holdB, holdA};
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign byteLane[g] = holdAll[g*DATA_W +: DATA_W];
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(CTRL_ADDR)) busRdData = ctrlRd;
    for (int k = 0; k < LANES; k++)
      if (busAddr == ADDR_W'(k + 1)) busRdData = byteLane[k];
  end

  // R5: a counted event at the top value returns to zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incA && countA == CNT_MAX) |=> (countA == '0));

  // R4: in chaining mode the upper half moves only on a carry
  p_chain_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.chain && !(strobe.incA && countA == CNT_MAX)) |=> $stable(countB));

  // R3: in independent mode an input-B edge steps counter B by one
  p_indep_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.chain && strobe.incB) |=> (countB == $past(countB) + 1'b1));

  // R7: the capture takes the values from just before the edge
  p_snap_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.snap |=> (holdA == $past(countA)) && (holdB == $past(countB)));

  // R9: the holding registers do not follow the live count
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.snap |=> $stable(holdA) && $stable(holdB));
endmodule

// File: rtl/dual_event_counter.sv
module dual_event_counter
  import evc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtInA,
  input  logic              evtInB,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);
  cntStrobe_t        strobe;
  logic [DATA_W-1:0] ctrlRd;

  evc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2), .NUM_IN(2)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evtIn     ({evtInB, evtInA}),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busWrData (busWrData),
    .strobe    (strobe),
    .ctrlRd    (ctrlRd)
  );

  evc_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busAddr   (busAddr),
    .ctrlRd    (ctrlRd),
    .busRdData (busRdData)
  );
endmodule

// File: tb/sim_dual_event_counter.sv
`timescale 1ns/1ps
module sim_dual_event_counter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evtInA = 1'b0, evtInB = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  dual_event_counter u0 (
    .clk(clk), .rstN(rstN), .evtInA(evtInA), .evtInB(evtInB),
    .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData), .busRdData(busRdData)
  );

  // behavioural reference model
  int mCntA = 0, mCntB = 0, mHoldA = 0, mHoldB = 0;
  bit mPolA, mPolB, mChain, mSnap;
  bit mS1A, mS2A, mPrvA, mS1B, mS2B, mPrvB;
  bit eA, eB, carry;

  always @(posedge clk) begin
    if (!rstN) begin
      mCntA = 0; mCntB = 0; mHoldA = 0; mHoldB = 0;
      mPolA = 0; mPolB = 0; mChain = 0; mSnap = 0;
      mS1A = 0; mS2A = 0; mPrvA = 0; mS1B = 0; mS2B = 0; mPrvB = 0;
    end else begin
      eA = mPolA ? (mS2A && !mPrvA) : (!mS2A && mPrvA);
      eB = mPolB ? (mS2B && !mPrvB) : (!mS2B && mPrvB);
      carry = eA && (mCntA == 65535);
      if (mSnap) begin mHoldA = mCntA; mHoldB = mCntB; end
      if (eA) mCntA = (mCntA + 1) % 65536;
      if (mChain ? carry : eB) mCntB = (mCntB + 1) % 65536;
      mPrvA = mS2A; mS2A = mS1A; mS1A = evtInA;
      mPrvB = mS2B; mS2B = mS1B; mS1B = evtInB;
      mSnap = 0;
      if (busWr && busAddr == 3'd0) begin
        mPolA = busWrData[0]; mPolB = busWrData[1];
        mChain = busWrData[2]; mSnap = busWrData[3];
      end
    end
  end

  function automatic logic [7:0] modelRd(input logic [2:0] a);
    case (a)
      3'd0: return {4'b0, mSnap, mChain, mPolB, mPolA};
      3'd1: return mHoldA[7:0];
      3'd2: return mHoldA[15:8];
      3'd3: return mHoldB[7:0];
      3'd4: return mHoldB[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // per-cycle comparison against the model (R1 for control, R9 for holding bytes)
  always begin
    @(negedge clk);
    #2;
    if (rstN && !finished) begin
      checks++;
      if (busRdData !== modelRd(busAddr)) begin
        fails++;
        $display("FAIL %s model compare addr %0d: got %02h expected %02h",
                 (busAddr == 3'd0) ? "R1" : "R9", busAddr, busRdData, modelRd(busAddr));
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    tick();
    busWr = 1'b0;
  endtask

  task automatic snap(input logic [7:0] cfg);
    wr(3'd0, cfg | 8'h08);
    tick();
  endtask

  task automatic expectRd(input string tag, input logic [2:0] a, input logic [7:0] exp);
    busAddr = a;
    #1;
    checks++;
    if (busRdData !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: got %02h expected %02h", tag, a, busRdData, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    tick();

    // reset state
    expectRd("R1", 3'd0, 8'h00);
    for (int a = 1; a <= 4; a++) expectRd("R9", 3'(a), 8'h00);

    // control register layout, high bits read zero
    wr(3'd0, 8'h03);
    expectRd("R1", 3'd0, 8'h03);
    wr(3'd0, 8'hF3);
    expectRd("R1", 3'd0, 8'h03);

    // writes elsewhere ignored, unused addresses read zero
    wr(3'd2, 8'hAA);
    expectRd("R10", 3'd2, 8'h00);
    expectRd("R10", 3'd0, 8'h03);
    expectRd("R10", 3'd7, 8'h00);

    // latency, self-clear and capture on the counting edge
    evtInA = 1'b1;
    tick();
    wr(3'd0, 8'h0B);
    expectRd("R8", 3'd0, 8'h0B);
    tick();
    expectRd("R8", 3'd0, 8'h03);
    expectRd("R7", 3'd1, 8'h00);
    snap(8'h03);
    expectRd("R6", 3'd1, 8'h01);

    // falling polarity on input A
    wr(3'd0, 8'h02);
    evtInA = 1'b0; waitN(4); snap(8'h02);
    expectRd("R2", 3'd1, 8'h02);
    evtInA = 1'b1; waitN(4); snap(8'h02);
    expectRd("R2", 3'd1, 8'h02);

    // independent counter B, rising polarity
    for (int p = 0; p < 3; p++) begin
      evtInB = 1'b1; waitN(3);
      evtInB = 1'b0; waitN(3);
    end
    waitN(4); snap(8'h02);
    expectRd("R3", 3'd3, 8'h03);
    expectRd("R3", 3'd4, 8'h00);
    expectRd("R3", 3'd1, 8'h02);

    // chaining: run counter A up to 0xFFFF while toggling B
    wr(3'd0, 8'h06);
    for (int n = 0; n < 65533; n++) begin
      evtInA = 1'b0; evtInB = ~evtInB; tick();
      evtInA = 1'b1; evtInB = ~evtInB; tick();
    end
    waitN(4); snap(8'h06);
    expectRd("R5", 3'd1, 8'hFF);
    expectRd("R5", 3'd2, 8'hFF);
    expectRd("R4", 3'd3, 8'h03);
    expectRd("R4", 3'd4, 8'h00);
    evtInA = 1'b0; waitN(4); snap(8'h06);
    expectRd("R5", 3'd1, 8'h00);
    expectRd("R5", 3'd2, 8'h00);
    expectRd("R4", 3'd3, 8'h04);

    // holding registers stay put while counting continues
    for (int n = 0; n < 10; n++) begin
      evtInA = 1'b1; tick();
      evtInA = 1'b0; tick();
    end
    waitN(4);
    expectRd("R9", 3'd1, 8'h00);
    snap(8'h06);
    expectRd("R9", 3'd1, 8'h0A);
    expectRd("R4", 3'd3, 8'h04);

    wr(3'd5, 8'hFF);
    expectRd("R10", 3'd5, 8'h00);
    expectRd("R10", 3'd0, 8'h06);

    tick();
    summary();
  end
endmodule